// File: doc/BRIEF.md
# Serial EEPROM Read Master

This block is a serial-flash-style EEPROM reader that a CPU drives through four 16-bit registers. Firmware stores an EEPROM address and a word count, then writes the control register with the start bit set. The block lowers chip select, sends a command (a data read with a 16-bit address, or a status read), and then clocks in the requested number of words. The bus is SPI mode 0: SCLK idles low, MOSI changes on the falling edge, MISO is sampled on the rising edge, and bits go most significant first.

After each word the block raises a ready flag and stops SCLK. Reading the data register takes the word, clears the flag and lets the next word start. Chip select stays low across the whole burst and rises once the last word has been taken. A control bit can also produce a single short low pulse on chip select while no transfer is running.

The SCLK rate is one of four divisions of the system clock. The control register selects the division, and each division is a parameter.

Top module: `spi_eeprom_reader`

## Requirements
- R1: After reset the control register (offset 0) reads 0x0001, the data (offset 1), address (offset 2) and length (offset 3) registers read 0, chip select is high and SCLK is low.
- R2: In the control register, bits 0 (function), 6:5 (rate) and 8:7 (spare) store the written value. Bit 2 always reads 0. Bits 15:9 read 0, and writing them has no effect.
- R3: With function bit 0 = 0, starting a transfer sends opcode 0x03 and then the 16-bit address, in SPI mode 0 and most significant bit first, with chip select low. It then receives the requested number of 8-bit words.
- R4: With function bit 0 = 1, starting a transfer sends only opcode 0x05 and then receives the requested number of 8-bit words.
- R5: Start bit 1 and busy bit 4 of the control register both read 1 from the write that starts a transfer until the final word is taken. Chip select stays low for that whole time and goes high when start bit 1 clears.
- R6: Ready bit 3 reads 1 once a word has been received. The word is then readable at offset 1. While bit 3 is set, SCLK produces no edges. Reading offset 1 clears bit 3 and starts the next word, or ends the burst after the last word.
- R7: Rate bits 6:5 = 0, 1, 2, 3 give an SCLK high phase of HALF_0, HALF_1, HALF_2 and HALF_3 system clocks (4, 8, 13 and 27 by default).
- R8: A length of 0 sends only the command and address, then ends the transfer with chip select high.
- R9: Control register writes during a transfer are ignored, including changes to rate and function and any new start or pulse request. Reading offset 1 while bit 3 is clear returns the last word and does not affect the transfer.
- R10: Writing bit 2 = 1 with bit 1 = 0 while idle drives chip select low for exactly PULSE_CYC system clocks, with SCLK held low. Chip select then returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (reading the data register consumes a word) |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_csn | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The hardest case is a register access that arrives in the middle of a burst: a control write or a premature data read while the header bits are still shifting. Such an access has to leave both the serial stream and the stored configuration untouched. The bench issues these accesses right after the start write, while a behavioural EEPROM model is still decoding the command. It then checks the returned words, the decoded opcode, the total number of SCLK rising edges and the length of every SCLK high phase against the rate in force at the start. A second hard case is the stalled clock while ready is set. To reach it, the bench deliberately leaves a word unread for many cycles and confirms that no SCLK edge appears.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_WAIT,
      ST_PULSE
   } seq_state_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_DATA = 2'd1;
   localparam logic [1:0] REG_ADDR = 2'd2;
   localparam logic [1:0] REG_LEN  = 2'd3;

   localparam logic [7:0] OPC_READ = 8'h03;
   localparam logic [7:0] OPC_STAT = 8'h05;
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
   parameter int HALF_0 = 4,
   parameter int HALF_1 = 8,
   parameter int HALF_2 = 13,
   parameter int HALF_3 = 27,
   parameter int CNT_W  = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] rate,
   output logic       tick
);
   localparam int HALF_ARR [4] = '{HALF_0, HALF_1, HALF_2, HALF_3};

   logic [CNT_W-1:0] half_tab [4];
   logic [CNT_W-1:0] cnt_q;

   for (genvar gi = 0; gi < 4; gi++) begin : g_tab
      if (HALF_ARR[gi] < 2 || HALF_ARR[gi] >= (1 << CNT_W)) begin : g_bad
         $error("spi_rate_div: half period out of range");
      end
      assign half_tab[gi] = CNT_W'(HALF_ARR[gi] - 1);
   end

   assign tick = en && (cnt_q == half_tab[rate]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!en)     cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R7
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
   parameter int SH_W   = 24,
   parameter int DATA_W = 8,
   parameter int BC_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [SH_W-1:0]   load_data,
   input  logic [BC_W-1:0]   load_bits,
   input  logic              tick,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic [DATA_W-1:0] rx,
   output logic              done
);
   logic [SH_W-1:0] tx_q;
   logic [BC_W-1:0] left_q;

   if (DATA_W > SH_W) begin : g_bad
      $error("spi_bit_shifter: word wider than shifter");
   end

   assign mosi = tx_q[SH_W-1];
   assign done = tick && sclk && (left_q == BC_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         left_q <= '0;
         sclk   <= 1'b0;
         rx     <= '0;
      end else if (load) begin
         tx_q   <= load_data;
         left_q <= load_bits;
         sclk   <= 1'b0;
      end else if (tick) begin
         if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[DATA_W-2:0], miso};
         end else begin
            sclk   <= 1'b0;
            left_q <= left_q - BC_W'(1);
            tx_q   <= tx_q << 1;
         end
      end
   end

   AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi)); // R3
endmodule

// File: rtl/spi_eeprom_reader.sv
module spi_eeprom_reader
   import spi_eeprom_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int LEN_W     = 16,
   parameter int HALF_0    = 4,
   parameter int HALF_1    = 8,
   parameter int HALF_2    = 13,
   parameter int HALF_3    = 27,
   parameter int PULSE_CYC = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [1:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        spi_sclk,
   output logic        spi_mosi,
   output logic        spi_csn,
   input  logic        spi_miso
);
   localparam int HDR_W = 8 + ADDR_W;
   localparam int SH_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
   localparam int BC_W  = $clog2(SH_W + 1);
   localparam int PC_W  = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_data
      $error("spi_eeprom_reader: DATA_W must be 8 or 16");
   end
   if (ADDR_W != 8 && ADDR_W != 16) begin : g_bad_addr
      $error("spi_eeprom_reader: ADDR_W must be 8 or 16");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("spi_eeprom_reader: LEN_W must be 1..16");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("spi_eeprom_reader: PULSE_CYC must be positive");
   end

   seq_state_e         st_q;
   logic               cfg_func;
   logic [1:0]         cfg_rate;
   logic [1:0]         cfg_spare;
   logic [DATA_W-1:0]  data_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LEN_W-1:0]   len_q;
   logic [LEN_W-1:0]   remain_q;
   logic [PC_W-1:0]    pcnt_q;
   logic               csn_q;
   logic               ready_q;

   logic               sh_load;
   logic [SH_W-1:0]    sh_data;
   logic [BC_W-1:0]    sh_bits;
   logic               sh_tick;
   logic               sh_done;
   logic [DATA_W-1:0]  sh_rx;
   logic               shift_en;

   wire acc_wr  = bus_sel & bus_wr;
   wire ctrl_wr = acc_wr & (bus_addr == REG_CTRL);
   wire addr_wr = acc_wr & (bus_addr == REG_ADDR);
   wire len_wr  = acc_wr & (bus_addr == REG_LEN);
   wire data_rd = bus_sel & bus_rd & (bus_addr == REG_DATA);
   wire idle    = (st_q == ST_IDLE);
   wire go_flag = (st_q == ST_HDR) || (st_q == ST_DATA) || (st_q == ST_WAIT);
   wire busy    = !idle;
   wire start   = ctrl_wr & idle & bus_wdata[1];
   wire pulse_g = ctrl_wr & idle & ~bus_wdata[1] & bus_wdata[2];

   assign shift_en = (st_q == ST_HDR) || (st_q == ST_DATA);
   assign spi_csn  = csn_q;

   // header and word loads for the shifter
   always_comb begin
      sh_load = 1'b0;
      sh_data = '0;
      sh_bits = BC_W'(DATA_W);
      if (start) begin
         sh_load = 1'b1;
         if (bus_wdata[0]) begin
            sh_data = SH_W'(OPC_STAT) << (SH_W - 8);
            sh_bits = BC_W'(8);
         end else begin
            sh_data = SH_W'({OPC_READ, addr_q}) << (SH_W - HDR_W);
            sh_bits = BC_W'(HDR_W);
         end
      end else if (st_q == ST_HDR && sh_done && remain_q != '0) begin
         sh_load = 1'b1;
      end else if (st_q == ST_WAIT && data_rd && remain_q != '0) begin
         sh_load = 1'b1;
      end
   end

   spi_rate_div #(
      .HALF_0 (HALF_0),
      .HALF_1 (HALF_1),
      .HALF_2 (HALF_2),
      .HALF_3 (HALF_3),
      .CNT_W  (8)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (shift_en),
      .rate  (cfg_rate),
      .tick  (sh_tick)
   );

   spi_bit_shifter #(
      .SH_W   (SH_W),
      .DATA_W (DATA_W),
      .BC_W   (BC_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_data (sh_data),
      .load_bits (sh_bits),
      .tick      (sh_tick),
      .miso      (spi_miso),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi),
      .rx        (sh_rx),
      .done      (sh_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         cfg_func  <= 1'b1;
         cfg_rate  <= 2'd0;
         cfg_spare <= 2'd0;
         data_q    <= '0;
         addr_q    <= '0;
         len_q     <= '0;
         remain_q  <= '0;
         pcnt_q    <= '0;
         csn_q     <= 1'b1;
         ready_q   <= 1'b0;
      end else begin
         if (ctrl_wr && idle) begin
            cfg_func  <= bus_wdata[0];
            cfg_rate  <= bus_wdata[6:5];
            cfg_spare <= bus_wdata[8:7];
         end
         if (addr_wr) addr_q <= bus_wdata[ADDR_W-1:0];
         if (len_wr)  len_q  <= bus_wdata[LEN_W-1:0];
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q     <= ST_HDR;
                  csn_q    <= 1'b0;
                  remain_q <= len_q;
               end else if (pulse_g) begin
                  st_q   <= ST_PULSE;
                  csn_q  <= 1'b0;
                  pcnt_q <= PC_W'(PULSE_CYC - 1);
               end
            end
            ST_HDR: begin
               if (sh_done) begin
                  if (remain_q == '0) begin
                     st_q  <= ST_IDLE;
                     csn_q <= 1'b1;
                  end else begin
                     st_q <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (sh_done) begin
                  data_q   <= sh_rx;
                  ready_q  <= 1'b1;
                  remain_q <= remain_q - LEN_W'(1);
                  st_q     <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (data_rd) begin
                  ready_q <= 1'b0;
                  if (remain_q == '0) begin
                     st_q  <= ST_IDLE;
                     csn_q <= 1'b1;
                  end else begin
                     st_q <= ST_DATA;
                  end
               end
            end
            ST_PULSE: begin
               if (pcnt_q == '0) begin
                  st_q  <= ST_IDLE;
                  csn_q <= 1'b1;
               end else begin
                  pcnt_q <= pcnt_q - PC_W'(1);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (bus_addr)
         REG_CTRL: bus_rdata = {7'd0, cfg_spare, cfg_rate, busy, ready_q,
                                1'b0, go_flag, cfg_func};
         REG_DATA: bus_rdata = 16'(data_q);
         REG_ADDR: bus_rdata = 16'(addr_q);
         default:  bus_rdata = 16'(len_q);
      endcase
   end

   AST_SCLK_QUIET_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      spi_csn |-> !spi_sclk); // R10
   AST_READY_INSIDE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> !spi_csn); // R6
   AST_READY_STALLS_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> $stable(spi_sclk)); // R6
   AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctrl_wr) |=> ($stable(cfg_rate) && $stable(cfg_func))); // R9
   AST_GO_END_RAISES_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(go_flag) |-> spi_csn); // R5
endmodule

// File: tb/tb_spi_eeprom_reader.sv
module tb_spi_eeprom_reader;
   localparam int CLK_PERIOD = 10;
   localparam int H0 = 4, H1 = 8, H2 = 13, H3 = 27;
   localparam int PCYC = 4;
   localparam logic [7:0] STAT_VAL = 8'hA6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        spi_sclk, spi_mosi, spi_csn;
   logic        spi_miso = 1'b0;

   int checks = 0;
   int fails  = 0;
   int exp_half = H0;
   int hi_run = 0;
   logic [7:0] last_word = 8'h00;

   spi_eeprom_reader #(
      .DATA_W(8), .ADDR_W(16), .LEN_W(16),
      .HALF_0(H0), .HALF_1(H1), .HALF_2(H2), .HALF_3(H3),
      .PULSE_CYC(PCYC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_csn(spi_csn), .spi_miso(spi_miso)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] mem_at(input logic [15:0] a);
      return (a[7:0] ^ a[15:8]) + 8'h5B;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // behavioural EEPROM model (mode 0)
   int         rises = 0;
   logic [7:0] s_op = 8'h00;
   logic [15:0] s_addr = 16'h0;
   logic [7:0] s_byte = 8'h00;

   always @(negedge spi_csn) begin
      rises = 0; s_op = 8'h00; s_addr = 16'h0; spi_miso = 1'b0;
   end
   always @(posedge spi_sclk) if (spi_csn === 1'b0) begin
      if (rises < 8) s_op = {s_op[6:0], spi_mosi};
      else if (rises < 24 && s_op == 8'h03) s_addr = {s_addr[14:0], spi_mosi};
      rises++;
   end
   always @(negedge spi_sclk) if (spi_csn === 1'b0) begin
      int hdr, k;
      hdr = (s_op == 8'h03) ? 24 : 8;
      if (rises >= hdr) begin
         k = rises - hdr;
         if (k % 8 == 0)
            s_byte = (s_op == 8'h03) ? mem_at(s_addr + 16'(k / 8)) : STAT_VAL;
         spi_miso = s_byte[7 - (k % 8)];
      end
   end

   // per-clock comparison: SCLK high phase length, SCLK quiet with CS high
   always @(negedge clk) if (rst_n) begin
      checks++;
      if (spi_csn === 1'b1 && spi_sclk !== 1'b0) begin
         fails++;
         $display("FAIL R10 actual sclk=%b expected 0 with cs high", spi_sclk);
      end
      if (spi_sclk === 1'b1) hi_run++;
      else if (hi_run != 0) begin
         check("R7 high phase", hi_run, exp_half);
         hi_run = 0;
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wait_ready(output bit ok);
      logic [15:0] v;
      ok = 1'b0;
      for (int p = 0; p < 5000; p++) begin
         bus_read(2'd0, v);
         if (v[3]) begin ok = 1'b1; break; end
      end
   endtask

   task automatic wait_idle();
      logic [15:0] v;
      for (int p = 0; p < 5000; p++) begin
         bus_read(2'd0, v);
         if (!v[4]) break;
      end
   endtask

   function automatic int half_of(input int r);
      case (r)
         0: return H0;
         1: return H1;
         2: return H2;
         default: return H3;
      endcase
   endfunction

   task automatic burst(input bit func, input int rate, input logic [15:0] a,
                        input int len, input bit hold, input string tag);
      logic [15:0] v;
      logic [7:0]  exp;
      bit ok;
      int r0;
      exp_half = half_of(rate);
      bus_write(2'd2, a);
      bus_write(2'd3, 16'(len));
      bus_write(2'd0, 16'((rate << 5) | 2 | int'(func)));
      bus_read(2'd0, v);
      check({tag, " R5 start+busy set"}, int'({v[4], v[1]}), 3);
      check({tag, " R5 cs low"}, int'(spi_csn), 0);
      for (int i = 0; i < len; i++) begin
         wait_ready(ok);
         check({tag, " R6 ready seen"}, int'(ok), 1);
         if (hold && i == 0) begin
            r0 = rises;
            repeat (60) @(negedge clk);
            check({tag, " R6 sclk stalled"}, rises, r0);
            bus_read(2'd0, v);
            check({tag, " R6 ready held"}, int'(v[3]), 1);
         end
         bus_read(2'd1, v);
         exp = func ? STAT_VAL : mem_at(a + 16'(i));
         check({tag, func ? " R4 word" : " R3 word"}, int'(v), int'(exp));
         last_word = v[7:0];
      end
      if (len == 0) wait_idle();
      bus_read(2'd0, v);
      check({tag, " R5 start+busy clear"}, int'({v[4], v[1], v[3]}), 0);
      check({tag, " R5 cs high"}, int'(spi_csn), 1);
      check({tag, func ? " R4 opcode" : " R3 opcode"}, int'(s_op),
            func ? 8'h05 : 8'h03);
      if (!func) check({tag, " R3 address"}, int'(s_addr), int'(a));
      check({tag, " R3 bit count"}, rises, (func ? 8 : 24) + 8 * len);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int lowcnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      bus_read(2'd0, v); check("R1 ctrl", int'(v), 16'h0001);
      bus_read(2'd1, v); check("R1 data", int'(v), 0);
      bus_read(2'd2, v); check("R1 addr", int'(v), 0);
      bus_read(2'd3, v); check("R1 len", int'(v), 0);
      check("R1 cs/sclk", int'({spi_csn, spi_sclk}), 2);
      // R2 writable mask
      bus_write(2'd0, 16'hFE81);
      bus_read(2'd0, v); check("R2 high bits dropped", int'(v), 16'h0081);
      bus_write(2'd0, 16'h01E1);
      bus_read(2'd0, v); check("R2 stored fields", int'(v), 16'h01E1);
      bus_write(2'd0, 16'h0001);
      // R3 data read with hold, R4 status read, R7 rates
      burst(1'b0, 0, 16'h1234, 3, 1'b1, "T1");
      burst(1'b1, 3, 16'h0000, 2, 1'b0, "T2");
      burst(1'b0, 1, 16'hFFFF, 2, 1'b0, "T3 R7");
      burst(1'b0, 2, 16'h00A0, 1, 1'b0, "T4 R7");
      // R8 zero length
      burst(1'b0, 0, 16'h4321, 0, 1'b0, "T5 R8");
      // R9 writes and early reads during a transfer
      exp_half = H0;
      bus_write(2'd2, 16'h0777);
      bus_write(2'd3, 16'd1);
      bus_write(2'd0, 16'h0002);
      bus_read(2'd1, v); check("R9 early data read", int'(v), int'(last_word));
      bus_write(2'd0, 16'h0067);
      begin
         bit ok;
         wait_ready(ok); check("R9 ready", int'(ok), 1);
      end
      bus_read(2'd1, v); check("R9 word", int'(v), int'(mem_at(16'h0777)));
      bus_read(2'd0, v); check("R9 ctrl unchanged", int'(v), 16'h0000);
      check("R9 opcode", int'(s_op), 8'h03);
      check("R9 bit count", rises, 32);
      repeat (10) @(negedge clk);
      check("R9 no pulse", int'(spi_csn), 1);
      // R10 chip select pulse
      bus_write(2'd0, 16'h0004);
      lowcnt = 0;
      while (spi_csn === 1'b0 && lowcnt < 100) begin
         lowcnt++;
         @(negedge clk);
      end
      check("R10 pulse width", lowcnt, PCYC);
      check("R10 pulse sclk edges", rises, 0);
      bus_read(2'd0, v); check("R10 bit2 reads 0", int'(v), 16'h0000);
      check("R10 cs high after", int'(spi_csn), 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule